// File: doc/BRIEF.md
# Per-Instruction Execute Period Controller

This block chooses how long each instruction spends in the execute stage. A classifier upstream predicts a delay class for each instruction. The block turns that class into a period, measured in ticks of a fast reference clock, and pulses a completion strobe when that period runs out. Every tick is 0.2 ns. The worst-case period is 4.0 ns, which is 20 ticks, and every class period is a fraction of it.

A result can look correct at the short deadline even though it has not settled yet. To catch this, the block takes two samples of the execute result. The first is taken at the class deadline and the second at the worst-case deadline, both counted from the same start. If the two samples differ, the block flags a timing violation and asks for a replay. It then holds the pipeline in a stall for four worst-case periods. These cover refetch, decode, classify and execute. The replayed execute runs at the worst-case period and ends with a second completion strobe.

Event counters for each class and for violations are brought out for observation. Generating real clocks and scaling the supply voltage are handled elsewhere.

Top module: `clk_period_ctrl`

## Requirements
- R1: After reset, `done_o`, `tviol_o`, `replay_o` and `stall_o` are low, all counters are zero and `period_o` reads 20.
- R2: With `cls_mode_i`=0 (two classes), class 0 takes 11 ticks and class 1 takes 20. An instruction accepted at edge 0 raises `done_o` for one cycle right after edge N, where N is the class period.
- R3: With `cls_mode_i`=1 (three classes), classes 0, 1 and 2 take 9, 13 and 20 ticks, with the same timing as R2.
- R4: With `cls_mode_i`=2 (four classes), classes 0 to 3 take 5, 10, 15 and 20 ticks.
- R5: A class ID at or above the configured class count is treated as the slowest class of that mode (20 ticks). `cls_mode_i`=3 is single-class mode: every instruction takes 20 ticks and counts as class 0.
- R6: The result is sampled again at edge 20. If it differs from the sample taken at the class deadline, `tviol_o` and `replay_o` pulse for one cycle right after edge 20. If they match, neither pulses.
- R7: After a violation, `stall_o` stays high for 80 ticks (4 × 20), starting in the same cycle as `tviol_o`, and `period_o` reads 20. `done_o` pulses once at the end of the stall, when the replay completes.
- R8: `instr_valid_i` is ignored while an instruction is in flight or during a stall. No counter changes and the timing is unaffected.
- R9: `class_cnt_o` field k, at bits [k*16 +: 16], counts accepted instructions whose effective class is k.
- R10: `viol_cnt_o` increments by one for each detected violation.
- R11: A result that settles before a slower class deadline completes at that deadline with no violation and no replay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference tick clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| instr_valid_i | input | 1 | New instruction offered (taken only when idle) |
| class_id_i | input | 2 | Predicted delay class |
| cls_mode_i | input | 2 | 0: two classes, 1: three, 2: four, 3: single |
| exec_res_i | input | 32 | Execute result being timed |
| done_o | output | 1 | Execute-complete strobe |
| tviol_o | output | 1 | Timing violation pulse |
| replay_o | output | 1 | Worst-case replay request pulse |
| stall_o | output | 1 | Penalty stall active |
| period_o | output | 7 | Period of the current or last instruction, in ticks |
| class_cnt_o | output | 64 | Four 16-bit per-class accept counters |
| viol_cnt_o | output | 16 | Violation counter |

## Verification
The bench targets four kinds of fault. The first is the off-by-one deadline in every mode: a controller that counts the acceptance edge as a tick would strobe one cycle early. The second is out-of-range class IDs: a design that indexes its table blindly would return a short period. The third is results that settle between the two deadlines. A design that compares at the wrong edge, or compares against an updated sample, would either miss the violation or flag a fast result that was placed in a slow class. The fourth is offers made during execution and during the stall: a controller that accepts them would bump the counters and restart the period.

// File: rtl/clk_period_pkg.sv
package clk_period_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_PEN  = 2'd2
  } ctl_state_e;

  localparam int unsigned NUM_CLASSES = 4;

  // class period as a number of twentieths of the worst-case period
  function automatic int unsigned frac_ticks(int unsigned worst, int unsigned twentieths);
    return (worst * twentieths) / 20;
  endfunction

endpackage

// File: rtl/cp_class_map.sv
module cp_class_map
  import clk_period_pkg::*;
#(
  parameter int unsigned WORST_TICKS = 20,
  parameter int unsigned TICK_W      = 7,
  parameter int unsigned CLS_W       = 2
) (
  input  logic [1:0]        mode_i,
  input  logic [CLS_W-1:0]  cls_i,
  output logic [CLS_W-1:0]  eff_cls_o,
  output logic [TICK_W-1:0] per_o
);

  localparam logic [TICK_W-1:0] T_W  = TICK_W'(WORST_TICKS);
  localparam logic [TICK_W-1:0] T_2A = TICK_W'(frac_ticks(WORST_TICKS, 11));
  localparam logic [TICK_W-1:0] T_3A = TICK_W'(frac_ticks(WORST_TICKS, 9));
  localparam logic [TICK_W-1:0] T_3B = TICK_W'(frac_ticks(WORST_TICKS, 13));
  localparam logic [TICK_W-1:0] T_4A = TICK_W'(frac_ticks(WORST_TICKS, 5));
  localparam logic [TICK_W-1:0] T_4B = TICK_W'(frac_ticks(WORST_TICKS, 10));
  localparam logic [TICK_W-1:0] T_4C = TICK_W'(frac_ticks(WORST_TICKS, 15));

  logic [CLS_W:0] n_cls;

  always_comb begin
    unique case (mode_i)
      2'd0:    n_cls = (CLS_W+1)'(2);
      2'd1:    n_cls = (CLS_W+1)'(3);
      2'd2:    n_cls = (CLS_W+1)'(4);
      default: n_cls = (CLS_W+1)'(1);
    endcase
  end

  // out-of-range class falls back to the slowest class of the mode
  assign eff_cls_o = ({1'b0, cls_i} < n_cls) ? cls_i : CLS_W'(n_cls - (CLS_W+1)'(1));

  always_comb begin
    per_o = T_W;
    unique case (mode_i)
      2'd0: if (eff_cls_o == CLS_W'(0)) per_o = T_2A;
      2'd1: begin
        if (eff_cls_o == CLS_W'(0))      per_o = T_3A;
        else if (eff_cls_o == CLS_W'(1)) per_o = T_3B;
      end
      2'd2: begin
        if (eff_cls_o == CLS_W'(0))      per_o = T_4A;
        else if (eff_cls_o == CLS_W'(1)) per_o = T_4B;
        else if (eff_cls_o == CLS_W'(2)) per_o = T_4C;
      end
      default: per_o = T_W;
    endcase
  end

endmodule

// File: rtl/cp_shadow.sv
module cp_shadow #(
  parameter int unsigned RES_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sample_en_i,
  input  logic             per_worst_i,
  input  logic [RES_W-1:0] res_i,
  output logic             mismatch_o
);

  logic [RES_W-1:0] early_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          early_q <= '0;
    else if (sample_en_i) early_q <= res_i;
  end

  // with a worst-case class both samples coincide, nothing to compare
  assign mismatch_o = !per_worst_i && (res_i != early_q);

endmodule

// File: rtl/cp_seq.sv
module cp_seq
  import clk_period_pkg::*;
#(
  parameter int unsigned WORST_TICKS    = 20,
  parameter int unsigned PENALTY_STAGES = 4,
  parameter int unsigned TICK_W         = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [TICK_W-1:0] per_i,
  input  logic              mismatch_i,
  output logic              accept_o,
  output logic              sample_en_o,
  output logic              per_worst_o,
  output logic              viol_evt_o,
  output logic              done_o,
  output logic              err_o,
  output logic              replay_o,
  output logic              stall_o,
  output logic [TICK_W-1:0] per_o
);

  localparam int unsigned PEN_TICKS = PENALTY_STAGES * WORST_TICKS;
  localparam logic [TICK_W-1:0] T_W = TICK_W'(WORST_TICKS);
  localparam logic [TICK_W-1:0] T_P = TICK_W'(PEN_TICKS);

  ctl_state_e        state_q;
  logic [TICK_W-1:0] cnt_q;
  logic [TICK_W-1:0] per_q;
  logic              done_q, err_q, rep_q;
  logic              at_worst;

  assign at_worst    = (state_q == ST_RUN) && (cnt_q == T_W);
  assign accept_o    = (state_q == ST_IDLE) && start_i;
  assign sample_en_o = (state_q == ST_RUN) && (cnt_q == per_q);
  assign per_worst_o = (per_q == T_W);
  assign viol_evt_o  = at_worst && mismatch_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      per_q   <= T_W;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      rep_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      rep_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_RUN;
            cnt_q   <= TICK_W'(1);
            per_q   <= per_i;
          end
        end
        ST_RUN: begin
          if (cnt_q == per_q) done_q <= 1'b1;
          if (at_worst) begin
            if (mismatch_i) begin
              err_q   <= 1'b1;
              rep_q   <= 1'b1;
              state_q <= ST_PEN;
              cnt_q   <= TICK_W'(1);
              per_q   <= T_W;
            end else begin
              state_q <= ST_IDLE;
            end
          end else begin
            cnt_q <= cnt_q + TICK_W'(1);
          end
        end
        ST_PEN: begin
          if (cnt_q == T_P) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            cnt_q <= cnt_q + TICK_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o   = done_q;
  assign err_o    = err_q;
  assign replay_o = rep_q;
  assign stall_o  = (state_q == ST_PEN);
  assign per_o    = per_q;

  // R2
  done_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) done_o |=> !done_o);
  // R6
  err_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) err_o |=> !err_o);
  // R7
  pen_period_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) stall_o |-> per_q == T_W);
  // R7
  tick_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) cnt_q <= T_P);

endmodule

// File: rtl/cp_event_cnt.sv
module cp_event_cnt #(
  parameter int unsigned NCLS  = 4,
  parameter int unsigned CLS_W = 2,
  parameter int unsigned CNT_W = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  accept_i,
  input  logic [CLS_W-1:0]      eff_cls_i,
  input  logic                  viol_evt_i,
  output logic [NCLS*CNT_W-1:0] class_cnt_o,
  output logic [CNT_W-1:0]      viol_cnt_o
);

  for (genvar k = 0; k < NCLS; k++) begin : g_cls
    logic [CNT_W-1:0] c_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    c_q <= '0;
      else if (accept_i && eff_cls_i == CLS_W'(k))    c_q <= c_q + CNT_W'(1);
    end
    assign class_cnt_o[k*CNT_W +: CNT_W] = c_q;
  end

  logic [CNT_W-1:0] v_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         v_q <= '0;
    else if (viol_evt_i) v_q <= v_q + CNT_W'(1);
  end
  assign viol_cnt_o = v_q;

endmodule

// File: rtl/clk_period_ctrl.sv
module clk_period_ctrl
  import clk_period_pkg::*;
#(
  parameter int unsigned WORST_TICKS    = 20,
  parameter int unsigned PENALTY_STAGES = 4,
  parameter int unsigned RES_W          = 32,
  parameter int unsigned CNT_W          = 16,
  parameter int unsigned CLS_W          = $clog2(NUM_CLASSES),
  parameter int unsigned TICK_W         = $clog2(PENALTY_STAGES * WORST_TICKS + 1)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         instr_valid_i,
  input  logic [CLS_W-1:0]             class_id_i,
  input  logic [1:0]                   cls_mode_i,
  input  logic [RES_W-1:0]             exec_res_i,
  output logic                         done_o,
  output logic                         tviol_o,
  output logic                         replay_o,
  output logic                         stall_o,
  output logic [TICK_W-1:0]            period_o,
  output logic [NUM_CLASSES*CNT_W-1:0] class_cnt_o,
  output logic [CNT_W-1:0]             viol_cnt_o
);

  logic [CLS_W-1:0]  eff_cls;
  logic [TICK_W-1:0] new_per;
  logic accept, sample_en, per_worst, viol_evt, mismatch;

  cp_class_map #(.WORST_TICKS(WORST_TICKS), .TICK_W(TICK_W), .CLS_W(CLS_W)) u_map (
    .mode_i   (cls_mode_i),
    .cls_i    (class_id_i),
    .eff_cls_o(eff_cls),
    .per_o    (new_per)
  );

  cp_seq #(.WORST_TICKS(WORST_TICKS), .PENALTY_STAGES(PENALTY_STAGES), .TICK_W(TICK_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (instr_valid_i),
    .per_i      (new_per),
    .mismatch_i (mismatch),
    .accept_o   (accept),
    .sample_en_o(sample_en),
    .per_worst_o(per_worst),
    .viol_evt_o (viol_evt),
    .done_o     (done_o),
    .err_o      (tviol_o),
    .replay_o   (replay_o),
    .stall_o    (stall_o),
    .per_o      (period_o)
  );

  cp_shadow #(.RES_W(RES_W)) u_shadow (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sample_en_i(sample_en),
    .per_worst_i(per_worst),
    .res_i      (exec_res_i),
    .mismatch_o (mismatch)
  );

  cp_event_cnt #(.NCLS(NUM_CLASSES), .CLS_W(CLS_W), .CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept),
    .eff_cls_i  (eff_cls),
    .viol_evt_i (viol_evt),
    .class_cnt_o(class_cnt_o),
    .viol_cnt_o (viol_cnt_o)
  );

  // R6
  viol_replay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tviol_o |-> (replay_o && stall_o));
  // R10
  viol_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tviol_o |-> (viol_cnt_o == $past(viol_cnt_o) + CNT_W'(1)));

endmodule

// File: tb/tb_clk_period_ctrl.sv
module tb_clk_period_ctrl;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        instr_valid_i = 1'b0;
  logic [1:0]  class_id_i = '0;
  logic [1:0]  cls_mode_i = '0;
  logic [31:0] exec_res_i = 32'h0000_1000;
  logic        done_o, tviol_o, replay_o, stall_o;
  logic [6:0]  period_o;
  logic [63:0] class_cnt_o;
  logic [15:0] viol_cnt_o;

  clk_period_ctrl dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .instr_valid_i(instr_valid_i),
    .class_id_i(class_id_i), .cls_mode_i(cls_mode_i), .exec_res_i(exec_res_i),
    .done_o(done_o), .tviol_o(tviol_o), .replay_o(replay_o), .stall_o(stall_o),
    .period_o(period_o), .class_cnt_o(class_cnt_o), .viol_cnt_o(viol_cnt_o)
  );

  always #5 clk_i = ~clk_i;

  int    n_chk = 0;
  int    n_fail = 0;
  string cur_tag = "R1";
  bit    cmp_on = 1'b0;

  // behavioural reference
  int m_ph = 0;
  int m_t = 0;
  int m_per = 20;
  int m_samp = 0;
  int m_cls[4] = '{0, 0, 0, 0};
  int m_viol = 0;
  bit e_done = 0, e_err = 0;

  function automatic int ref_ticks(int mode, int cls);
    int tbl2[2] = '{11, 20};
    int tbl3[3] = '{9, 13, 20};
    int tbl4[4] = '{5, 10, 15, 20};
    case (mode)
      0: return (cls < 2) ? tbl2[cls] : 20;
      1: return (cls < 3) ? tbl3[cls] : 20;
      2: return tbl4[cls];
      default: return 20;
    endcase
  endfunction

  function automatic int ref_eff(int mode, int cls);
    int n;
    n = (mode == 0) ? 2 : (mode == 1) ? 3 : (mode == 2) ? 4 : 1;
    return (cls < n) ? cls : n - 1;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_ph = 0; m_t = 0; m_per = 20; m_samp = 0; m_viol = 0;
      for (int k = 0; k < 4; k++) m_cls[k] = 0;
      e_done = 0; e_err = 0;
    end else begin
      e_done = 0; e_err = 0;
      if (m_ph == 0) begin
        if (instr_valid_i) begin
          m_ph = 1; m_t = 1;
          m_per = ref_ticks(int'(cls_mode_i), int'(class_id_i));
          m_cls[ref_eff(int'(cls_mode_i), int'(class_id_i))]++;
        end
      end else if (m_ph == 1) begin
        if (m_t == m_per) begin m_samp = int'(exec_res_i); e_done = 1; end
        if (m_t == 20) begin
          if (int'(exec_res_i) != m_samp) begin
            e_err = 1; m_viol++; m_ph = 2; m_t = 1; m_per = 20;
          end else m_ph = 0;
        end else m_t++;
      end else begin
        if (m_t == 80) begin e_done = 1; m_ph = 0; end
        else m_t++;
      end
    end
  end

  task automatic chk(string tag, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) begin
    if (cmp_on) begin
      chk(cur_tag, "done_o", done_o, e_done);
      chk("R6", "tviol_o", tviol_o, e_err);
      chk("R6", "replay_o", replay_o, e_err);
      chk("R7", "stall_o", stall_o, m_ph == 2);
      chk(cur_tag, "period_o", period_o, m_per);
      chk("R10", "viol_cnt_o", viol_cnt_o, m_viol);
      for (int k = 0; k < 4; k++)
        chk("R9", "class_cnt_o", class_cnt_o[k*16 +: 16], m_cls[k]);
    end
  end

  // settle: first edge after acceptance at which the final result is present
  task automatic run_instr(int mode, int cls, int settle, string tag, bit poke);
    logic [31:0] oldv, newv;
    int j;
    oldv = exec_res_i;
    newv = exec_res_i + 32'h1357_9BDF;
    @(negedge clk_i);
    cur_tag = tag;
    cls_mode_i = mode[1:0];
    class_id_i = cls[1:0];
    instr_valid_i = 1'b1;
    @(negedge clk_i);
    instr_valid_i = 1'b0;
    j = 0;
    while ((j < 25 || m_ph != 0) && j < 200) begin
      exec_res_i = (j + 1 >= settle) ? newv : oldv;
      instr_valid_i = poke && (j == 3 || j == 40);
      if (poke && j == 3) class_id_i = 2'd3;
      @(negedge clk_i);
      j++;
    end
    instr_valid_i = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1", "done_o", done_o, 0);
    chk("R1", "tviol_o", tviol_o, 0);
    chk("R1", "replay_o", replay_o, 0);
    chk("R1", "stall_o", stall_o, 0);
    chk("R1", "period_o", period_o, 20);
    chk("R1", "class_cnt_o", class_cnt_o, 0);
    chk("R1", "viol_cnt_o", viol_cnt_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    cmp_on = 1'b1;

    run_instr(0, 0, 3, "R2", 0);
    run_instr(0, 1, 15, "R2", 0);
    run_instr(1, 0, 2, "R3", 0);
    run_instr(1, 1, 2, "R3", 0);
    run_instr(1, 2, 2, "R3", 0);
    run_instr(2, 0, 1, "R4", 0);
    run_instr(2, 1, 1, "R4", 0);
    run_instr(2, 2, 1, "R4", 0);
    run_instr(2, 3, 1, "R4", 0);
    run_instr(0, 3, 5, "R5", 0);
    run_instr(1, 3, 5, "R5", 0);
    run_instr(3, 0, 5, "R5", 0);
    run_instr(2, 0, 12, "R6", 0);
    run_instr(0, 0, 18, "R7", 0);
    run_instr(1, 0, 10, "R8", 1);
    run_instr(2, 2, 4, "R11", 0);
    repeat (3) @(negedge clk_i);

    chk("R9", "class0 count", class_cnt_o[15:0], 7);
    chk("R9", "class1 count", class_cnt_o[31:16], 4);
    chk("R9", "class2 count", class_cnt_o[47:32], 4);
    chk("R9", "class3 count", class_cnt_o[63:48], 1);
    chk("R10", "violations", viol_cnt_o, 3);
    chk("R8", "idle after pokes", stall_o, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule